// File: doc/BRIEF.md
# Write-Update Coherent Cache Controller

This block is the processor-side controller of one direct-mapped snooping cache. The cache keeps its coherence with a five-state write-update protocol. Every line is in one of five states: Invalid, Valid-Exclusive, Shared-Clean, Shared-Dirty or Dirty. For each processor access, the controller looks up the line and decides whether the access hits. It then runs the bus steps that the access needs, strictly one after another: write-back of a dirty victim, then a bus read or a bus write miss, then an update broadcast. After these steps it settles the line's new state. A write to a line that other caches also hold does not invalidate their copies. The controller broadcasts the new data instead. The new state depends on the wired shared signal that the bus returns with each acknowledge.

The processor side uses two valid/ready channels, one for requests and one for responses. While a request is in flight, the controller stalls the processor by holding `cpu_req_ready` low. A response stays on the port until the processor takes it. Bus transactions use a request/grant handshake followed by an acknowledge. Victim write-backs leave through a separate valid/ready channel that the memory can hold off.

Address layout: the low `IDX_W` bits select the line and the remaining upper bits form the tag. Bus and write-back addresses are `{tag, index}`.

Top module: `wu_cache_ctrl`

## Requirements
- R1: After reset, `cpu_req_ready` is 1 and `cpu_resp_valid`, `bus_req` and `wb_valid` are 0. Every line is Invalid, so the first access to any address misses. Once a line has been filled, it never returns to Invalid.
- R2: A read miss issues exactly one bus transaction with `bus_op` = 1 (read) to the requested address, and the response carries `bus_rdata` from the acknowledge cycle. The line becomes Shared-Clean if `bus_shared` is 1 in the acknowledge cycle, otherwise Valid-Exclusive.
- R3: A write miss issues `bus_op` = 2 (write miss) carrying the processor data, and the data is stored in the line. If `bus_shared` is 1 at that acknowledge, an update transaction (`bus_op` = 3) with the same address and data follows, and the line becomes Shared-Dirty. Otherwise no update is issued and the line becomes Dirty. `bus_shared` at the update's acknowledge does not change the outcome.
- R4: On a miss whose victim line is Shared-Dirty or Dirty, one write-back carrying the victim's old address `{old tag, index}` and its data completes before the access raises `bus_req`.
- R5: On a miss whose victim line is Invalid, Valid-Exclusive or Shared-Clean, no write-back is issued.
- R6: A read hit returns the line's data with no bus transaction, and the line's state is unchanged.
- R7: A write hit in Valid-Exclusive stores the data with no bus transaction, and the line becomes Dirty.
- R8: A write hit in Shared-Clean or Shared-Dirty issues one update (`bus_op` = 3) carrying the new data. The line becomes Shared-Dirty if `bus_shared` is 1 at that acknowledge, otherwise Dirty.
- R9: A write hit in Dirty completes with no bus transaction, and the line stays Dirty.
- R10: A request is taken when `cpu_req_valid` and `cpu_req_ready` are both 1. `cpu_req_ready` then stays 0 until the response has been taken. `cpu_resp_valid` and `cpu_resp_rdata` hold steady while `cpu_resp_ready` is 0. A write's response returns the data written.
- R11: `bus_req` stays 1, with `bus_op`, `bus_addr` and `bus_wdata` unchanged, until a cycle with `bus_gnt` = 1. The controller then waits for `bus_ack` and samples `bus_shared` and `bus_rdata` only in the acknowledge cycle. `bus_op` is 0 while no bus request is raised.
- R12: `wb_valid` stays 1, with `wb_addr` and `wb_data` unchanged, until a cycle with `wb_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address {tag, index} |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | Response valid |
| cpu_resp_ready | input | 1 | Processor takes the response |
| cpu_resp_rdata | output | DATA_W | Read data, or written data for writes |
| bus_req | output | 1 | Bus request |
| bus_op | output | 2 | 0 idle, 1 read, 2 write miss, 3 update |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Data for write miss and update, 0 for read |
| bus_gnt | input | 1 | Bus grant |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_shared | input | 1 | Wired shared line, meaningful in the acknowledge cycle |
| bus_rdata | input | DATA_W | Fill data, meaningful in the acknowledge cycle |
| wb_valid | output | 1 | Write-back valid |
| wb_ready | input | 1 | Memory takes the write-back |
| wb_addr | output | ADDR_W | Victim address |
| wb_data | output | DATA_W | Victim data |

## Verification
The bench first brings each line into a chosen state. For each of the four valid states it uses a setup access, and for Invalid it uses the first touch of each line. It then applies every combination of read or write, hit or miss, and shared asserted or not at the acknowledge. The hit/miss split separates the silent local paths from the write-back plus read or write-miss sequences. The shared choice separates Shared-Clean from Valid-Exclusive, and Shared-Dirty from Dirty. The resulting state is exposed through later accesses: a write hit that does or does not broadcast, and an eviction that does or does not write back. Outside the acknowledge cycle, the bench drives `bus_shared` to the opposite of its acknowledge value, so a controller that samples it in any other cycle lands in the wrong state. Grant, acknowledge, write-back ready and response ready are delayed by a rotating zero to two cycles, to exercise the hold rules of every channel.

// File: rtl/wu_pkg.sv
package wu_pkg;

  typedef enum logic [2:0] {
    LS_INV   = 3'd0,
    LS_EXCL  = 3'd1,
    LS_SHCLN = 3'd2,
    LS_SHDRT = 3'd3,
    LS_DRT   = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    BOP_NONE  = 2'd0,
    BOP_READ  = 2'd1,
    BOP_WMISS = 2'd2,
    BOP_UPD   = 2'd3
  } bus_op_t;

  function automatic logic needs_wb(line_st_t s);
    return (s == LS_SHDRT) || (s == LS_DRT);
  endfunction

endpackage

// File: rtl/wu_line_store.sv
module wu_line_store
  import wu_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  output line_st_t          lk_state,
  output logic [DATA_W-1:0] lk_data,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [TAG_W-1:0]  st_tag,
  input  line_st_t          st_state,
  input  logic [DATA_W-1:0] st_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_arr  [LINES];
  logic [TAG_W-1:0]  tag_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] dat_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_r  <= LS_INV;
          tag_r <= '0;
          dat_r <= '0;
        end else if (st_we && (st_idx == IDX_W'(g))) begin
          st_r  <= st_state;
          tag_r <= st_tag;
          dat_r <= st_data;
        end
      end
      assign st_arr[g]  = st_r;
      assign tag_arr[g] = tag_r;
      assign dat_arr[g] = dat_r;
    end
  endgenerate

  assign lk_state = st_arr[lk_idx];
  assign lk_tag   = tag_arr[lk_idx];
  assign lk_data  = dat_arr[lk_idx];

  // R1: a filled line is never sent back to Invalid
  assert_no_invalidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (st_state != LS_INV));

endmodule

// File: rtl/wu_seq.sv
module wu_seq
  import wu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  input  logic              cpu_resp_ready,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [ADDR_W-IDX_W-1:0] lk_tag,
  input  line_st_t          lk_state,
  input  logic [DATA_W-1:0] lk_data,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [ADDR_W-IDX_W-1:0] st_tag,
  output line_st_t          st_state,
  output logic [DATA_W-1:0] st_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WBACK, S_BREQ, S_BWAIT, S_RESP
  } seq_t;

  seq_t              cur, nxt;
  logic              r_write;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [DATA_W-1:0] r_wdata;
  bus_op_t           op_q, op_d;
  logic              upd_hit_q, upd_hit_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [ADDR_W-1:0] wba_q, wba_d;
  logic [DATA_W-1:0] wbd_q, wbd_d;
  logic              hit;

  assign hit    = (lk_state != LS_INV) && (lk_tag == r_tag);
  assign lk_idx = r_idx;
  assign st_idx = r_idx;
  assign st_tag = r_tag;

  always_comb begin
    nxt       = cur;
    op_d      = op_q;
    upd_hit_d = upd_hit_q;
    rdata_d   = rdata_q;
    wba_d     = wba_q;
    wbd_d     = wbd_q;
    st_we     = 1'b0;
    st_state  = lk_state;
    st_data   = r_wdata;
    case (cur)
      S_IDLE: if (cpu_req_valid) nxt = S_LOOK;
      S_LOOK: begin
        rdata_d = r_write ? r_wdata : lk_data;
        if (hit && !r_write) begin
          nxt = S_RESP;
        end else if (hit) begin
          st_we = 1'b1;
          if (lk_state == LS_SHCLN || lk_state == LS_SHDRT) begin
            op_d      = BOP_UPD;
            upd_hit_d = 1'b1;
            nxt       = S_BREQ;
          end else begin
            st_state = LS_DRT;
            nxt      = S_RESP;
          end
        end else begin
          op_d      = r_write ? BOP_WMISS : BOP_READ;
          upd_hit_d = 1'b0;
          wba_d     = {lk_tag, r_idx};
          wbd_d     = lk_data;
          nxt       = needs_wb(lk_state) ? S_WBACK : S_BREQ;
        end
      end
      S_WBACK: if (wb_ready) nxt = S_BREQ;
      S_BREQ:  if (bus_gnt) nxt = S_BWAIT;
      S_BWAIT: if (bus_ack) begin
        nxt = S_RESP;
        case (op_q)
          BOP_READ: begin
            st_we    = 1'b1;
            st_data  = bus_rdata;
            st_state = bus_shared ? LS_SHCLN : LS_EXCL;
            rdata_d  = bus_rdata;
          end
          BOP_WMISS: begin
            st_we    = 1'b1;
            st_state = bus_shared ? LS_SHDRT : LS_DRT;
            if (bus_shared) begin
              op_d      = BOP_UPD;
              upd_hit_d = 1'b0;
              nxt       = S_BREQ;
            end
          end
          BOP_UPD: if (upd_hit_q) begin
            st_we    = 1'b1;
            st_state = bus_shared ? LS_SHDRT : LS_DRT;
          end
          default: ;
        endcase
      end
      S_RESP: if (cpu_resp_ready) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= S_IDLE;
      r_write   <= 1'b0;
      r_idx     <= '0;
      r_tag     <= '0;
      r_wdata   <= '0;
      op_q      <= BOP_NONE;
      upd_hit_q <= 1'b0;
      rdata_q   <= '0;
      wba_q     <= '0;
      wbd_q     <= '0;
    end else begin
      cur       <= nxt;
      op_q      <= op_d;
      upd_hit_q <= upd_hit_d;
      rdata_q   <= rdata_d;
      wba_q     <= wba_d;
      wbd_q     <= wbd_d;
      if (cur == S_IDLE && cpu_req_valid) begin
        r_write <= cpu_req_write;
        r_idx   <= cpu_req_addr[IDX_W-1:0];
        r_tag   <= cpu_req_addr[ADDR_W-1:IDX_W];
        r_wdata <= cpu_req_wdata;
      end
    end
  end

  assign cpu_req_ready  = (cur == S_IDLE);
  assign cpu_resp_valid = (cur == S_RESP);
  assign cpu_resp_rdata = rdata_q;
  assign bus_req        = (cur == S_BREQ);
  assign bus_op         = bus_req ? op_q : BOP_NONE;
  assign bus_addr       = {r_tag, r_idx};
  assign bus_wdata      = (op_q == BOP_READ) ? '0 : r_wdata;
  assign wb_valid       = (cur == S_WBACK);
  assign wb_addr        = wba_q;
  assign wb_data        = wbd_q;

  assert_accept_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_resp_valid && !cpu_resp_ready) |=> (cpu_resp_valid && $stable(cpu_resp_rdata)));

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_op) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_wb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  assert_wb_excl_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !bus_req);

  assert_wb_then_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> bus_req);

endmodule

// File: rtl/wu_cache_ctrl.sv
module wu_cache_ctrl
  import wu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  input  logic              cpu_resp_ready,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, st_idx;
  logic [TAG_W-1:0]  lk_tag, st_tag;
  line_st_t          lk_state, st_state;
  logic [DATA_W-1:0] lk_data, st_data;
  logic              st_we;

  wu_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_state(lk_state), .lk_data(lk_data),
    .st_we(st_we), .st_idx(st_idx), .st_tag(st_tag), .st_state(st_state), .st_data(st_data)
  );

  wu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_ready(cpu_resp_ready),
    .cpu_resp_rdata(cpu_resp_rdata),
    .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_state(lk_state), .lk_data(lk_data),
    .st_we(st_we), .st_idx(st_idx), .st_tag(st_tag), .st_state(st_state), .st_data(st_data)
  );

endmodule

// File: tb/wu_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module wu_cache_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int TW = AW - IW;
  localparam int NL = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_ready, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_resp_valid, cpu_resp_ready = 1'b0;
  logic [DW-1:0] cpu_resp_rdata;
  logic bus_req;
  logic [1:0] bus_op;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 1'b0, bus_ack = 1'b0, bus_shared = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic wb_valid, wb_ready = 1'b0;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  always #2.5 clk = ~clk;

  wu_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_ready(cpu_resp_ready),
    .cpu_resp_rdata(cpu_resp_rdata),
    .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  // model of line contents: 0 Inv, 1 ValidExcl, 2 SharedClean, 3 SharedDirty, 4 Dirty
  int            mst [NL];
  logic [TW-1:0] mtg [NL];
  logic [DW-1:0] mdt [NL];

  bit            j_go = 0, j_acc = 0, j_sh = 0, got_done = 0, busy_ready_bad = 0, b_wait = 0;
  int            dl = 0, gcnt = 0, acnt = 0, wcnt = 0, rcnt = 0;
  int            got_wb_n, got_wb_pos, got_op_n;
  logic [AW-1:0] got_wb_addr;
  logic [DW-1:0] got_wb_data, got_rdata;
  logic [1:0]    got_op  [4];
  logic [AW-1:0] got_opa [4];
  logic [DW-1:0] got_opd [4];
  logic [AW-1:0] pend_addr;

  function automatic logic [DW-1:0] fill(input logic [AW-1:0] a);
    return {a, a ^ 8'h5A} ^ 16'h0F0F;
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // all stimulus and capture at the falling edge; each decision predicts the next rising edge
  always @(negedge clk) begin
    if (rst_n && j_go) begin
      if (!j_acc) begin
        cpu_req_valid = 1'b1;
        if (cpu_req_ready) j_acc = 1;
      end else begin
        cpu_req_valid = 1'b0;
        if (cpu_req_ready && !got_done) busy_ready_bad = 1;
      end
      cpu_resp_ready = 1'b0;
      if (cpu_resp_valid) begin
        if (rcnt == 0) begin
          cpu_resp_ready = 1'b1;
          got_rdata = cpu_resp_rdata;
          got_done = 1;
        end else rcnt--;
      end
      wb_ready = 1'b0;
      if (wb_valid) begin
        if (wcnt == 0) begin
          wb_ready = 1'b1;
          got_wb_n++;
          got_wb_pos = got_op_n;
          got_wb_addr = wb_addr;
          got_wb_data = wb_data;
          wcnt = dl;
        end else wcnt--;
      end
      // R11: shared carries the opposite value outside the acknowledge cycle
      bus_gnt = 1'b0;
      bus_ack = 1'b0;
      bus_shared = ~j_sh;
      if (b_wait) begin
        if (acnt == 0) begin
          bus_ack = 1'b1;
          bus_shared = j_sh;
          bus_rdata = fill(pend_addr);
          b_wait = 0;
        end else acnt--;
      end else if (bus_req) begin
        if (gcnt == 0) begin
          bus_gnt = 1'b1;
          if (got_op_n < 4) begin
            got_op[got_op_n]  = bus_op;
            got_opa[got_op_n] = bus_addr;
            got_opd[got_op_n] = bus_wdata;
          end
          got_op_n++;
          pend_addr = bus_addr;
          b_wait = 1;
          acnt = dl;
          gcnt = dl;
        end else gcnt--;
      end
    end
  end

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit sh);
    int idx, st, ns, e_n;
    bit hit, e_wb;
    logic [TW-1:0] tg;
    logic [1:0] e_op [2];
    logic [DW-1:0] e_rd;
    string rq, rqw;
    idx = int'(a[IW-1:0]);
    tg  = a[AW-1:IW];
    st  = mst[idx];
    hit = (st != 0) && (mtg[idx] == tg);
    e_wb = 0; e_n = 0; ns = st; rqw = "R5";
    e_op[0] = 2'd0; e_op[1] = 2'd0;
    if (hit) begin
      if (!w) begin rq = "R6"; e_rd = mdt[idx]; end
      else begin
        e_rd = d;
        if (st == 1 || st == 4) begin rq = (st == 1) ? "R7" : "R9"; ns = 4; end
        else begin rq = "R8"; e_op[0] = 2'd3; e_n = 1; ns = sh ? 3 : 4; end
        mdt[idx] = d;
      end
    end else begin
      if (st == 3 || st == 4) begin e_wb = 1; rqw = "R4"; end
      if (st == 0) rq = "R1";
      if (!w) begin
        if (st != 0) rq = "R2";
        e_op[0] = 2'd1; e_n = 1; ns = sh ? 2 : 1; e_rd = fill(a);
      end else begin
        if (st != 0) rq = "R3";
        e_op[0] = 2'd2; e_rd = d;
        if (sh) begin e_op[1] = 2'd3; e_n = 2; ns = 3; end
        else begin e_n = 1; ns = 4; end
      end
    end
    // launch
    @(posedge clk); #1;
    cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d; j_sh = sh;
    got_wb_n = 0; got_wb_pos = -1; got_op_n = 0; got_done = 0; busy_ready_bad = 0;
    j_acc = 0; b_wait = 0;
    gcnt = dl; acnt = dl; wcnt = dl; rcnt = dl;
    dl = (dl + 1) % 3;
    j_go = 1;
    while (!got_done) @(negedge clk);
    @(posedge clk); #1;
    j_go = 0;
    cpu_req_valid = 1'b0;
    @(negedge clk);
    cpu_resp_ready = 1'b0; bus_gnt = 1'b0; bus_ack = 1'b0; wb_ready = 1'b0;
    // checks
    check(rqw, got_wb_n, e_wb);
    if (e_wb) begin
      check("R4", got_wb_addr, {mtg[idx], a[IW-1:0]});
      check("R4", got_wb_data, mdt[idx]);
      check("R4", got_wb_pos, 0);
    end
    check(rq, got_op_n, e_n);
    for (int i = 0; i < e_n && i < got_op_n; i++) begin
      check(rq, got_op[i], e_op[i]);
      check("R11", got_opa[i], a);
      if (e_op[i] != 2'd1) check(rq, got_opd[i], d);
    end
    check(w ? "R10" : rq, got_rdata, e_rd);
    check("R10", busy_ready_bad, 0);
    if (!hit && !w) mdt[idx] = fill(a);
    if (!hit && w)  mdt[idx] = d;
    mst[idx] = ns;
    mtg[idx] = tg;
  endtask

  initial begin
    int k, tctr;
    logic [TW-1:0] t1, t2;
    for (int i = 0; i < NL; i++) begin mst[i] = 0; mtg[i] = '0; mdt[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs right after reset
    check("R1", cpu_req_ready, 1);
    check("R1", cpu_resp_valid, 0);
    check("R1", bus_req, 0);
    check("R1", wb_valid, 0);
    // R1: first touch of every line misses, from Invalid
    access(1'b0, {6'd0, 2'd0}, 16'h0, 1'b0);
    access(1'b0, {6'd1, 2'd1}, 16'h0, 1'b1);
    access(1'b1, {6'd2, 2'd2}, 16'hC0DE, 1'b0);
    access(1'b1, {6'd3, 2'd3}, 16'hBEEF, 1'b1);
    k = 0; tctr = 4;
    for (int s = 1; s <= 4; s++)
      for (int w = 0; w < 2; w++)
        for (int h = 0; h < 2; h++)
          for (int sh = 0; sh < 2; sh++) begin
            t1 = TW'(tctr); tctr++;
            // setup: s=1 read no-share, 2 read shared, 3 write shared, 4 write no-share
            access(s >= 3, {t1, IW'(k % NL)}, 16'h1000 + 16'(k), (s == 2) || (s == 3));
            if (h == 1) t2 = t1;
            else begin t2 = TW'(tctr); tctr++; end
            access(w[0], {t2, IW'(k % NL)}, 16'h8000 + 16'(k * 7), sh[0]);
            k++;
          end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule